// File: doc/BRIEF.md
# Two-Wire Register and RAM Slave with Power-Fail Lockout

This block is the serial front end of a battery-backed clock/calendar device. It listens on a two-wire bus and answers one fixed device address. A write transfer loads a 15-bit word pointer from two address bytes and then stores data bytes. A read transfer returns bytes starting at the current pointer. The pointer advances after every byte, so any number of bytes can follow in one burst.

The 32K-byte address space has three regions. Most of it is general-purpose RAM. Seven locations are a reserved gap. The top nine locations hold the clock registers: hundredths, control, seconds, minutes, hours, day, date, month and year. Here those registers are plain storage.

A power-fail input takes priority over everything else. It cuts off any transfer, clears the pointer and makes the slave deaf to the bus. After power returns, a recovery window must pass before the slave accepts writes again. Reads are still answered during that window.

Top module: `rtc_serial_slave`

## Requirements
- R1: After reset the slave does not drive SDA (`sda_oe` = 0), the pointer is 0000h and all storage reads 00h.
- R2: The slave acknowledges only the device byte 1101000 followed by the direction bit (D0h = write, D1h = read). Any other device byte gets no acknowledge, and the bytes after it also get none.
- R3: In a write transfer the slave acknowledges the device byte, the pointer high byte (bit 7 ignored), the pointer low byte and every data byte. Data bytes are stored at consecutive addresses starting at the pointer.
- R4: A read transfer (D1h) returns bytes starting at the current pointer, most significant bit first, advancing by one per byte. A master acknowledge asks for another byte. A master non-acknowledge ends the burst and SDA stays released.
- R5: The pointer wraps from 7FFFh to 0000h.
- R6: The reserved addresses 7FF0h to 7FF6h, and RAM addresses at or above the RAM depth, acknowledge writes but discard them, and read back 00h.
- R7: Addresses 7FF7h to 7FFFh are nine independent read/write byte registers.
- R8: An SDA fall while SCL is high (START) restarts at the device-byte phase from any point, even mid-byte. An SDA rise while SCL is high (STOP) ends the transfer. Bits clocked after a STOP are ignored until the next START.
- R9: Raising `pwr_fail` aborts the transfer, releases SDA and resets the pointer to 0000h.
- R10: While `pwr_fail` is high, all bus activity is ignored, including D1h.
- R11: For RECOVERY system-clock cycles after `pwr_fail` falls, D0h is not acknowledged. D1h is acknowledged and reads work. Once the window has elapsed, writes are accepted again.
- R12: `sda_oe` changes only while the synchronized SCL is low, or on a power-fail abort.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Bus clock line as sensed |
| sda_in | input | 1 | Bus data line as sensed |
| sda_oe | output | 1 | When 1, the pad pulls SDA low; otherwise SDA is released |
| pwr_fail | input | 1 | Supply out of tolerance; aborts and locks out the bus |

## Verification
The bench builds the slave with a 16-byte RAM and a 500-cycle recovery window. With a RAM this small, a low address such as 0010h already lies past the RAM depth, so the out-of-range RAM case sits next to real RAM cells. The 500-cycle window outlasts one bus byte but ends well inside the test. This lets the bench see a refused write-address byte, an accepted read inside the window, and accepted writes after it, all in one run. The tests at the top of the space cover the wrap, the reserved gap and all clock-register neighbours without needing a full-size RAM.

// File: rtl/rtc_slv_pkg.sv
package rtc_slv_pkg;

    localparam int ADDR_W = 15;
    localparam logic [6:0] DEV_ID = 7'b1101000;
    localparam logic [ADDR_W-1:0] HOLE_BASE = 15'h7FF0;
    localparam logic [ADDR_W-1:0] CLK_BASE = 15'h7FF7;
    localparam int CLK_REGS = 9;
    localparam int CLK_IW = $clog2(CLK_REGS);

    typedef enum logic [2:0] {
        ST_IDLE, ST_DEV, ST_AHI, ST_ALO, ST_WR, ST_ACK, ST_RD, ST_MACK
    } slv_state_e;

    typedef enum logic [1:0] {
        RGN_RAM, RGN_NONE, RGN_CLK
    } region_e;

    typedef struct packed {
        logic start;
        logic stop;
        logic scl_rise;
        logic scl_fall;
        logic scl_lvl;
        logic sda_lvl;
    } bus_ev_t;

    function automatic region_e map_addr(logic [ADDR_W-1:0] a, int depth);
        if (a >= CLK_BASE) return RGN_CLK;
        if (a >= HOLE_BASE) return RGN_NONE;
        if (int'(a) < depth) return RGN_RAM;
        return RGN_NONE;
    endfunction

endpackage

// File: rtl/bus_cond.sv
module bus_cond
    import rtc_slv_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_in,
    input  logic    sda_in,
    output bus_ev_t ev
);
    localparam int TOP = SYNC_STAGES - 1;

    logic [TOP:0] scl_sr;
    logic [TOP:0] sda_sr;
    logic scl_prev;
    logic sda_prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            scl_sr   <= '1;
            sda_sr   <= '1;
            scl_prev <= 1'b1;
            sda_prev <= 1'b1;
        end else begin
            scl_sr   <= {scl_sr[TOP-1:0], scl_in};
            sda_sr   <= {sda_sr[TOP-1:0], sda_in};
            scl_prev <= scl_sr[TOP];
            sda_prev <= sda_sr[TOP];
        end
    end

    always_comb begin
        ev.scl_lvl  = scl_sr[TOP];
        ev.sda_lvl  = sda_sr[TOP];
        ev.scl_rise = scl_sr[TOP] & ~scl_prev;
        ev.scl_fall = ~scl_sr[TOP] & scl_prev;
        ev.start    = scl_sr[TOP] & scl_prev & sda_prev & ~sda_sr[TOP];
        ev.stop     = scl_sr[TOP] & scl_prev & ~sda_prev & sda_sr[TOP];
    end

endmodule

// File: rtl/pf_lockout.sv
module pf_lockout #(
    parameter int RECOVERY = 1000
) (
    input  logic clk,
    input  logic rst,
    input  logic pwr_fail,
    output logic lock_busy
);
    localparam int CW = $clog2(RECOVERY + 1);

    logic [CW-1:0] hold_cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            hold_cnt <= '0;
        end else if (pwr_fail) begin
            hold_cnt <= CW'(RECOVERY);
        end else if (hold_cnt != '0) begin
            hold_cnt <= hold_cnt - 1'b1;
        end
    end

    assign lock_busy = pwr_fail | (hold_cnt != '0);

    AST_LOCK_ARMED: assert property (@(posedge clk) disable iff (rst)
        $fell(pwr_fail) |-> lock_busy); // R11

endmodule

// File: rtl/rtc_store.sv
module rtc_store
    import rtc_slv_pkg::*;
#(
    parameter int RAM_DEPTH = 256
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    output logic [7:0]        rdata
);
    localparam int RAM_AW = (RAM_DEPTH > 1) ? $clog2(RAM_DEPTH) : 1;

    logic [7:0] ram  [RAM_DEPTH];
    logic [7:0] regs [CLK_REGS];

    region_e             rgn;
    logic [RAM_AW-1:0]   ram_idx;
    logic [CLK_IW-1:0]   clk_idx;

    always_comb begin
        rgn     = map_addr(addr, RAM_DEPTH);
        ram_idx = addr[RAM_AW-1:0];
        clk_idx = CLK_IW'(addr[3:0] - 4'd7);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < RAM_DEPTH; i++) ram[i] <= '0;
            for (int j = 0; j < CLK_REGS; j++) regs[j] <= '0;
        end else if (wr_en) begin
            case (rgn)
                RGN_RAM: ram[ram_idx]  <= wdata;
                RGN_CLK: regs[clk_idx] <= wdata;
                default: ;
            endcase
        end
    end

    always_comb begin
        rdata = '0;
        case (rgn)
            RGN_RAM: rdata = ram[ram_idx];
            RGN_CLK: rdata = regs[clk_idx];
            default: rdata = '0;
        endcase
    end

endmodule

// File: rtl/rtc_serial_slave.sv
module rtc_serial_slave
    import rtc_slv_pkg::*;
#(
    parameter int RAM_DEPTH = 256,
    parameter int RECOVERY  = 1000
) (
    input  logic clk,
    input  logic rst,
    input  logic scl_in,
    input  logic sda_in,
    output logic sda_oe,
    input  logic pwr_fail
);
    bus_ev_t           ev;
    logic              lock_busy;
    slv_state_e        state;
    slv_state_e        after_ack;
    logic [3:0]        bitcnt;
    logic [7:0]        shreg;
    logic [6:0]        ptr_hi;
    logic [ADDR_W-1:0] ptr;
    logic              mack_ok;
    logic              wr_en;
    logic [7:0]        rd_byte;
    logic              byte_done;

    bus_cond #(.SYNC_STAGES(2)) u_cond (
        .clk    (clk),
        .rst    (rst),
        .scl_in (scl_in),
        .sda_in (sda_in),
        .ev     (ev)
    );

    pf_lockout #(.RECOVERY(RECOVERY)) u_lock (
        .clk       (clk),
        .rst       (rst),
        .pwr_fail  (pwr_fail),
        .lock_busy (lock_busy)
    );

    rtc_store #(.RAM_DEPTH(RAM_DEPTH)) u_store (
        .clk   (clk),
        .rst   (rst),
        .wr_en (wr_en),
        .addr  (ptr),
        .wdata (shreg),
        .rdata (rd_byte)
    );

    assign byte_done = ev.scl_fall && (bitcnt == 4'd8);
    assign wr_en = !pwr_fail && (state == ST_WR) && byte_done;

    always_ff @(posedge clk) begin
        if (rst || pwr_fail) begin
            state     <= ST_IDLE;
            after_ack <= ST_IDLE;
            bitcnt    <= '0;
            shreg     <= '0;
            ptr_hi    <= '0;
            ptr       <= '0;
            mack_ok   <= 1'b0;
            sda_oe    <= 1'b0;
        end else if (ev.start) begin
            state  <= ST_DEV;
            bitcnt <= '0;
        end else if (ev.stop) begin
            state <= ST_IDLE;
        end else begin
            case (state)
                ST_DEV, ST_AHI, ST_ALO, ST_WR: begin
                    if (ev.scl_rise && bitcnt < 4'd8) begin
                        shreg  <= {shreg[6:0], ev.sda_lvl};
                        bitcnt <= bitcnt + 4'd1;
                    end else if (byte_done) begin
                        state  <= ST_ACK;
                        sda_oe <= 1'b1;
                        case (state)
                            ST_DEV: begin
                                if (shreg[7:1] == DEV_ID && (shreg[0] || !lock_busy)) begin
                                    after_ack <= shreg[0] ? ST_RD : ST_AHI;
                                end else begin
                                    state  <= ST_IDLE;
                                    sda_oe <= 1'b0;
                                end
                            end
                            ST_AHI: begin
                                ptr_hi    <= shreg[6:0];
                                after_ack <= ST_ALO;
                            end
                            ST_ALO: begin
                                ptr       <= {ptr_hi, shreg};
                                after_ack <= ST_WR;
                            end
                            default: begin
                                ptr       <= ptr + 1'b1;
                                after_ack <= ST_WR;
                            end
                        endcase
                    end
                end
                ST_ACK: begin
                    if (ev.scl_fall) begin
                        if (after_ack == ST_RD) begin
                            shreg  <= rd_byte;
                            sda_oe <= ~rd_byte[7];
                            bitcnt <= 4'd1;
                            ptr    <= ptr + 1'b1;
                        end else begin
                            sda_oe <= 1'b0;
                            bitcnt <= '0;
                        end
                        state <= after_ack;
                    end
                end
                ST_RD: begin
                    if (ev.scl_fall) begin
                        if (bitcnt == 4'd8) begin
                            sda_oe <= 1'b0;
                            state  <= ST_MACK;
                        end else begin
                            sda_oe <= ~shreg[6];
                            shreg  <= {shreg[6:0], 1'b0};
                            bitcnt <= bitcnt + 4'd1;
                        end
                    end
                end
                ST_MACK: begin
                    if (ev.scl_rise) begin
                        mack_ok <= ~ev.sda_lvl;
                    end else if (ev.scl_fall) begin
                        if (mack_ok) begin
                            shreg  <= rd_byte;
                            sda_oe <= ~rd_byte[7];
                            bitcnt <= 4'd1;
                            ptr    <= ptr + 1'b1;
                            state  <= ST_RD;
                        end else begin
                            state <= ST_IDLE;
                        end
                    end
                end
                default: ;
            endcase
        end
    end

    AST_PF_ABORT: assert property (@(posedge clk) disable iff (rst)
        pwr_fail |=> (!sda_oe && state == ST_IDLE && ptr == '0)); // R9

    AST_LOCK_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        (lock_busy && !pwr_fail) |-> state != ST_WR); // R11

    AST_SDA_HOLD: assert property (@(posedge clk) disable iff (rst)
        (ev.scl_lvl && !pwr_fail) |=> $stable(sda_oe)); // R12

    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        (state == ST_IDLE) |-> !sda_oe); // R8

endmodule

// File: tb/rtc_serial_slave_test.sv
module rtc_serial_slave_test;
    localparam int CLK_PERIOD = 10;
    localparam int HP = 6;
    localparam int NVEC = 9;
    // {address, write data, expected read data}
    localparam logic [31:0] VEC [NVEC] = '{
        {16'h0000, 8'hA5, 8'hA5},   // R3 RAM
        {16'h000F, 8'h3C, 8'h3C},   // R3 last RAM cell
        {16'h0010, 8'h77, 8'h00},   // R6 beyond RAM depth
        {16'h7FF0, 8'h11, 8'h00},   // R6 hole start
        {16'h7FF6, 8'h22, 8'h00},   // R6 hole end
        {16'h7FF7, 8'h99, 8'h99},   // R7 hundredths
        {16'h7FF8, 8'h80, 8'h80},   // R7 control
        {16'h7FFC, 8'h5A, 8'h5A},   // R7 day
        {16'h7FFF, 8'h21, 8'h21}    // R7 year
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic scl_m = 1'b1;
    logic sda_m = 1'b1;
    logic pwr_fail = 1'b0;
    logic sda_oe;
    logic sda_bus;
    int n_checks = 0;
    int n_fails = 0;
    int hold_viol = 0;
    logic prev_scl = 1'b1;
    logic prev_oe = 1'b0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;
    assign sda_bus = sda_m & ~sda_oe;

    rtc_serial_slave #(.RAM_DEPTH(16), .RECOVERY(500)) uut (
        .clk      (clk),
        .rst      (rst),
        .scl_in   (scl_m),
        .sda_in   (sda_bus),
        .sda_oe   (sda_oe),
        .pwr_fail (pwr_fail)
    );

    // R12 monitor: output enable must not move while SCL has been high
    always @(negedge clk) begin
        if (!rst && !pwr_fail && scl_m && prev_scl && (sda_oe != prev_oe))
            hold_viol++;
        prev_scl = scl_m;
        prev_oe  = sda_oe;
    end

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s: actual %02h expected %02h", req, act, exp);
        end
    endtask

    task automatic hp();
        repeat (HP) @(negedge clk);
    endtask

    task automatic bstart();
        sda_m = 1'b1; hp();
        scl_m = 1'b1; hp();
        sda_m = 1'b0; hp();
        scl_m = 1'b0; hp();
    endtask

    task automatic bstop();
        sda_m = 1'b0; hp();
        scl_m = 1'b1; hp();
        sda_m = 1'b1; hp();
    endtask

    task automatic send_bit(input logic b);
        sda_m = b; hp();
        scl_m = 1'b1; hp();
        scl_m = 1'b0; hp();
    endtask

    task automatic wbyte(input logic [7:0] b, output logic ack);
        for (int i = 7; i >= 0; i--) send_bit(b[i]);
        sda_m = 1'b1; hp();
        scl_m = 1'b1; hp();
        ack = ~sda_bus;
        scl_m = 1'b0; hp();
    endtask

    task automatic rbyte(input logic give_ack, output logic [7:0] b);
        sda_m = 1'b1;
        for (int i = 7; i >= 0; i--) begin
            hp();
            scl_m = 1'b1; hp();
            b[i] = sda_bus;
            scl_m = 1'b0;
        end
        sda_m = ~give_ack; hp();
        scl_m = 1'b1; hp();
        scl_m = 1'b0; hp();
        sda_m = 1'b1;
    endtask

    task automatic set_ptr(input logic [15:0] a, input string req);
        logic ack;
        bstart();
        wbyte(8'hD0, ack); chk(req, {7'b0, ack}, 8'h01);
        wbyte(a[15:8], ack); chk(req, {7'b0, ack}, 8'h01);
        wbyte(a[7:0], ack); chk(req, {7'b0, ack}, 8'h01);
    endtask

    task automatic write_one(input logic [15:0] a, input logic [7:0] d, input string req);
        logic ack;
        set_ptr(a, req);
        wbyte(d, ack); chk(req, {7'b0, ack}, 8'h01);
        bstop();
    endtask

    task automatic read_one(input logic [15:0] a, output logic [7:0] d, input string req);
        logic ack;
        set_ptr(a, req);
        bstart();
        wbyte(8'hD1, ack); chk(req, {7'b0, ack}, 8'h01);
        rbyte(1'b0, d);
        bstop();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fails++;
            n_checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        logic ack;
        logic [7:0] d;
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (5) @(negedge clk);
        chk("R1 sda_oe after reset", {7'b0, sda_oe}, 8'h00);

        // Vector table: write every entry, then read every entry back
        for (int v = 0; v < NVEC; v++)
            write_one(VEC[v][31:16], VEC[v][15:8], "R3/R6/R7 write ack");
        for (int v = 0; v < NVEC; v++) begin
            read_one(VEC[v][31:16], d, "R4 read ack");
            chk("R3/R6/R7 readback", d, VEC[v][7:0]);
        end

        // R2 wrong device address
        bstart();
        wbyte(8'hA0, ack); chk("R2 foreign address nack", {7'b0, ack}, 8'h00);
        wbyte(8'h00, ack); chk("R2 following byte nack", {7'b0, ack}, 8'h00);
        bstop();

        // R3/R4 sequential burst
        set_ptr(16'h0002, "R3 pointer");
        wbyte(8'h01, ack); chk("R3 burst ack", {7'b0, ack}, 8'h01);
        wbyte(8'h02, ack); chk("R3 burst ack", {7'b0, ack}, 8'h01);
        wbyte(8'h03, ack); chk("R3 burst ack", {7'b0, ack}, 8'h01);
        bstop();
        set_ptr(16'h0002, "R4 pointer");
        bstart();
        wbyte(8'hD1, ack); chk("R4 read address ack", {7'b0, ack}, 8'h01);
        rbyte(1'b1, d); chk("R4 burst byte 0", d, 8'h01);
        rbyte(1'b1, d); chk("R4 burst byte 1", d, 8'h02);
        rbyte(1'b0, d); chk("R4 burst byte 2", d, 8'h03);
        bstop();
        chk("R4 released after nack", {7'b0, sda_oe}, 8'h00);

        // R5 wrap at top of space
        set_ptr(16'h7FFE, "R5 pointer");
        wbyte(8'h44, ack); wbyte(8'h55, ack); wbyte(8'h66, ack);
        chk("R5 write ack at wrap", {7'b0, ack}, 8'h01);
        bstop();
        set_ptr(16'h7FFE, "R5 pointer");
        bstart();
        wbyte(8'hD1, ack);
        rbyte(1'b1, d); chk("R5 month", d, 8'h44);
        rbyte(1'b1, d); chk("R5 year", d, 8'h55);
        rbyte(1'b0, d); chk("R5 wrapped to 0000", d, 8'h66);
        bstop();

        // R8 STOP then stray bits are ignored
        set_ptr(16'h0006, "R8 pointer");
        bstop();
        wbyte(8'hEE, ack); chk("R8 no ack after stop", {7'b0, ack}, 8'h00);
        bstop();
        read_one(16'h0006, d, "R8 read");
        chk("R8 stray bits not stored", d, 8'h00);

        // R8 START mid-byte restarts the address phase
        set_ptr(16'h0007, "R8 pointer");
        send_bit(1'b1); send_bit(1'b1); send_bit(1'b1);
        bstart();
        wbyte(8'hD0, ack); chk("R8 restart device ack", {7'b0, ack}, 8'h01);
        wbyte(8'h00, ack); wbyte(8'h07, ack); wbyte(8'h6B, ack);
        bstop();
        read_one(16'h0007, d, "R8 read");
        chk("R8 data after restart", d, 8'h6B);

        // R9/R10/R11 power fail
        set_ptr(16'h000A, "R9 pointer");
        wbyte(8'h12, ack);
        send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
        pwr_fail = 1'b1;
        repeat (3) @(negedge clk);
        chk("R9 sda released on power fail", {7'b0, sda_oe}, 8'h00);
        bstop();
        bstart();
        wbyte(8'hD1, ack); chk("R10 ignored while failing", {7'b0, ack}, 8'h00);
        bstop();
        pwr_fail = 1'b0;
        bstart();
        wbyte(8'hD0, ack); chk("R11 write refused in recovery", {7'b0, ack}, 8'h00);
        bstop();
        bstart();
        wbyte(8'hD1, ack); chk("R11 read allowed in recovery", {7'b0, ack}, 8'h01);
        rbyte(1'b0, d); chk("R9 pointer reset to 0000", d, 8'h66);
        bstop();
        repeat (600) @(negedge clk);
        write_one(16'h000B, 8'h34, "R11 write after recovery");
        read_one(16'h000B, d, "R11 read");
        chk("R11 data after recovery", d, 8'h34);

        chk("R12 oe moves only with SCL low", 8'(hold_viol), 8'h00);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

endmodule